// File: doc/BRIEF.md
# Serial Host Control and Readout Port

This block is the host-facing side of a digital audio receiver. A host controller drives three wires: a shift clock, a serial data line and a latch strobe. Each transaction starts with an 8-bit address shifted in while the strobe is low. A pulse on the strobe then decodes it. A command-write address opens a 16-bit data phase, and the next strobe fall commits that word to the configuration register. The configuration register drives the receiver's control fields directly.

A readout address instead arms one of two captured status words: the 32-bit channel-status word or the 80-bit subcode Q word. A leading flag bit appears on the serial output at the strobe's falling edge. Each later falling edge of the shift clock advances the output by one bit. The output enable is high only during a readout. Everywhere else the pad driver outside the block holds the pin in high impedance.

All three host wires pass through two-flop synchronizers into the system clock domain, and edges are detected there. The controller has three states: `ST_IDLE` (collecting address bits), `ST_WRITE` (collecting command bits) and `ST_READ` (driving readout bits). It has four named transitions:
- IDLE_TO_WRITE: a strobe fall with the command address decoded.
- IDLE_TO_READ: a strobe fall with a readout address decoded.
- WRITE_TO_IDLE: any strobe fall.
- READ_TO_IDLE: any strobe rise.

Top module: `host_serial_port`

## Requirements
- R1: The address is the last 8 bits shifted in while idle, with the first of them as the most significant bit. 8'b0101_0111 selects command write, 8'b1001_0111 selects channel-status readout and 8'b0001_0111 selects subcode Q readout. Any other address, or fewer than 8 bits, leaves the block idle with `sout_oe_o` low.
- R2: Command bit 0 is shifted first. Bit 4 drives `sys_stop_o`, bits 6:5 drive `demod_sel_o`, bits 8:7 drive `echo_sel_o`, bit 9 drives `echo_vflag_o`, bit 10 drives `analog_mode_o` and bits 13:11 drive `fmt_sel_o`. The first 16 data bits are the word, and any bits after them are dropped.
- R3: Command bits 0 to 3, 14 and 15 have no effect on any output.
- R4: While `rst_n` is low and after it is released, every configuration output is 0 and `sout_oe_o` is 0.
- R5: After a channel-status address, the strobe fall raises `sout_oe_o` and puts a flag of 1 on `sout_o`. Each following shift-clock fall presents the next of the 32 data bits.
- R6: After a subcode Q address, the flag is the value of `sq_crc_ok_i` at the strobe fall. The 80 data bits follow, one per shift-clock fall.
- R7: Data leaves with the most significant byte first, and each byte goes LSB first. Once the last bit has been shifted out, `sout_o` reads 0.
- R8: `sout_oe_o` is high only from a readout's strobe fall until the next strobe rise, and never during a command write.
- R9: While `lock_err_i` is high during a channel-status readout, the readout is cleared, and every bit still to come reads 0. A subcode Q readout ignores `lock_err_i`.
- R10: A command write that ends with fewer than 16 data bits leaves all configuration outputs unchanged.
- R11: Data is taken on rising shift-clock edges, and `sout_o` changes only on falling edges (or on a lock clear). A rising edge never changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Host shift clock |
| sdata_i | input | 1 | Host serial data |
| latch_i | input | 1 | Host latch strobe |
| lock_err_i | input | 1 | Receiver lock error, system clock domain |
| cs_word_i | input | CS_W | Captured channel-status word |
| sq_word_i | input | SQ_W | Captured subcode Q word |
| sq_crc_ok_i | input | 1 | Subcode Q check passed |
| sout_o | output | 1 | Serial readout data |
| sout_oe_o | output | 1 | Readout pad enable (low means high impedance) |
| sys_stop_o | output | 1 | System stop |
| demod_sel_o | output | 2 | Demodulated input select |
| echo_sel_o | output | 2 | Input echoed on the data-out pin |
| echo_vflag_o | output | 1 | Echo replaced by validity flag |
| analog_mode_o | output | 1 | Analog source mode |
| fmt_sel_o | output | 3 | Audio output format |

## Verification
The assertions assume three things about the inputs. Each host wire holds its level for at least three system clocks, so every edge survives the synchronizers as one clean event. `sdata_i` is settled before each rising shift-clock edge. `lock_err_i` and the captured words are already synchronous to `clk`. The stimulus keeps within these limits: every wire phase lasts four system clocks, data is set three clocks before each rising edge, and the status words and the check flag change only while the block is idle.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_CMD = 8'b0101_0111;
    localparam logic [ADDR_W-1:0] ADDR_CS  = 8'b1001_0111;
    localparam logic [ADDR_W-1:0] ADDR_SQ  = 8'b0001_0111;
    localparam int CMD_W  = 16;
    localparam int FLD_LO = 4;
    localparam int FLD_HI = 13;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } hsp_state_e;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= d_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hsp_cmd_reg.sv
module hsp_cmd_reg #(
    parameter int CMD_W  = 16,
    parameter int FLD_LO = 4,
    parameter int FLD_HI = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 shift_i,
    input  logic                 bit_i,
    input  logic                 commit_i,
    output logic [FLD_HI-FLD_LO:0] fld_o
);
    localparam int FLD_W = FLD_HI - FLD_LO + 1;
    localparam int CNT_W = $clog2(CMD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);

    logic [CNT_W-1:0] cnt_q;
    logic [FLD_W-1:0] stage_q;
    logic [FLD_W-1:0] fld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            stage_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (shift_i) begin
            for (int i = 0; i < FLD_W; i++) begin
                if (cnt_q == CNT_W'(FLD_LO + i)) stage_q[i] <= bit_i;
            end
            if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else if (commit_i && cnt_q == CNT_FULL) begin
            fld_q <= stage_q;
        end
    end

    assign fld_o = fld_q;
endmodule

// File: rtl/hsp_readout.sv
module hsp_readout #(
    parameter int CS_W = 32,
    parameter int SQ_W = 80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_cs_i,
    input  logic            load_sq_i,
    input  logic [CS_W-1:0] cs_word_i,
    input  logic [SQ_W-1:0] sq_word_i,
    input  logic            sq_ok_i,
    input  logic            adv_i,
    input  logic            clr_i,
    output logic            bit_o
);
    localparam int SR_W   = SQ_W + 1;
    localparam int CS_NB  = CS_W / 8;
    localparam int SQ_NB  = SQ_W / 8;
    localparam int CS_PAD = SR_W - 1 - CS_W;

    logic [CS_W-1:0] cs_stream;
    logic [SQ_W-1:0] sq_stream;
    logic [SR_W-1:0] sr_q;

    for (genvar j = 0; j < CS_W; j++) begin : g_cs
        assign cs_stream[j] = cs_word_i[(CS_NB - 1 - j/8)*8 + (j%8)];
    end
    for (genvar j = 0; j < SQ_W; j++) begin : g_sq
        assign sq_stream[j] = sq_word_i[(SQ_NB - 1 - j/8)*8 + (j%8)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_cs_i) begin
            sr_q <= {{CS_PAD{1'b0}}, cs_stream, 1'b1};
        end else if (load_sq_i) begin
            sr_q <= {sq_stream, sq_ok_i};
        end else if (clr_i) begin
            sr_q <= '0;
        end else if (adv_i) begin
            sr_q <= {1'b0, sr_q[SR_W-1:1]};
        end
    end

    assign bit_o = sr_q[0];
endmodule

// File: rtl/host_serial_port.sv
module host_serial_port
    import hsp_pkg::*;
#(
    parameter int CS_W        = 32,
    parameter int SQ_W        = 80,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_i,
    input  logic            sdata_i,
    input  logic            latch_i,
    input  logic            lock_err_i,
    input  logic [CS_W-1:0] cs_word_i,
    input  logic [SQ_W-1:0] sq_word_i,
    input  logic            sq_crc_ok_i,
    output logic            sout_o,
    output logic            sout_oe_o,
    output logic            sys_stop_o,
    output logic [1:0]      demod_sel_o,
    output logic [1:0]      echo_sel_o,
    output logic            echo_vflag_o,
    output logic            analog_mode_o,
    output logic [2:0]      fmt_sel_o
);
    localparam int ACNT_W = $clog2(ADDR_W + 1);
    localparam logic [ACNT_W-1:0] ACNT_FULL = ACNT_W'(ADDR_W);
    localparam int FLD_W = FLD_HI - FLD_LO + 1;

    logic [2:0] sync_q;
    logic       sclk_s, latch_s, sdata_s;
    logic       sclk_d, latch_d;
    logic       sclk_rise, sclk_fall, latch_rise, latch_fall;

    hsp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sdata_i, latch_i, sclk_i}),
        .q_o   (sync_q)
    );

    assign sclk_s  = sync_q[0];
    assign latch_s = sync_q[1];
    assign sdata_s = sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            latch_d <= 1'b0;
        end else begin
            sclk_d  <= sclk_s;
            latch_d <= latch_s;
        end
    end

    assign sclk_rise  =  sclk_s  & ~sclk_d;
    assign sclk_fall  = ~sclk_s  &  sclk_d;
    assign latch_rise =  latch_s & ~latch_d;
    assign latch_fall = ~latch_s &  latch_d;

    hsp_state_e state_q, state_d;

    // address collection
    logic [ADDR_W-1:0] addr_q;
    logic [ACNT_W-1:0] acnt_q;
    logic              addr_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            acnt_q <= '0;
        end else if (state_q != ST_IDLE || latch_fall) begin
            acnt_q <= '0;
        end else if (sclk_rise) begin
            addr_q <= {addr_q[ADDR_W-2:0], sdata_s};
            if (acnt_q != ACNT_FULL) acnt_q <= acnt_q + 1'b1;
        end
    end

    assign addr_full = (acnt_q == ACNT_FULL);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (latch_fall && addr_full) begin
                    if (addr_q == ADDR_CMD) state_d = ST_WRITE;
                    else if (addr_q == ADDR_CS || addr_q == ADDR_SQ) state_d = ST_READ;
                end
            end
            ST_WRITE: if (latch_fall) state_d = ST_IDLE;
            ST_READ:  if (latch_rise) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-state control outputs
    logic cmd_start, cmd_shift, cmd_commit;
    logic load_cs, load_sq, rd_adv, rd_clr, rd_oe;
    logic rd_is_cs_q;

    always_comb begin
        cmd_start  = 1'b0;
        cmd_shift  = 1'b0;
        cmd_commit = 1'b0;
        load_cs    = 1'b0;
        load_sq    = 1'b0;
        rd_adv     = 1'b0;
        rd_clr     = 1'b0;
        rd_oe      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_start = latch_fall && addr_full && (addr_q == ADDR_CMD);
                load_cs   = latch_fall && addr_full && (addr_q == ADDR_CS);
                load_sq   = latch_fall && addr_full && (addr_q == ADDR_SQ);
            end
            ST_WRITE: begin
                cmd_shift  = sclk_rise;
                cmd_commit = latch_fall;
            end
            ST_READ: begin
                rd_oe  = 1'b1;
                rd_adv = sclk_fall;
                rd_clr = rd_is_cs_q && lock_err_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_is_cs_q <= 1'b0;
        else if (load_cs) rd_is_cs_q <= 1'b1;
        else if (load_sq) rd_is_cs_q <= 1'b0;
    end

    logic [FLD_W-1:0] fld;

    hsp_cmd_reg #(.CMD_W(CMD_W), .FLD_LO(FLD_LO), .FLD_HI(FLD_HI)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (cmd_start),
        .shift_i  (cmd_shift),
        .bit_i    (sdata_s),
        .commit_i (cmd_commit),
        .fld_o    (fld)
    );

    logic rd_bit;

    hsp_readout #(.CS_W(CS_W), .SQ_W(SQ_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_cs_i (load_cs),
        .load_sq_i (load_sq),
        .cs_word_i (cs_word_i),
        .sq_word_i (sq_word_i),
        .sq_ok_i   (sq_crc_ok_i),
        .adv_i     (rd_adv),
        .clr_i     (rd_clr),
        .bit_o     (rd_bit)
    );

    assign sout_oe_o     = rd_oe;
    assign sout_o        = rd_oe & rd_bit;
    assign sys_stop_o    = fld[0];
    assign demod_sel_o   = fld[2:1];
    assign echo_sel_o    = fld[4:3];
    assign echo_vflag_o  = fld[5];
    assign analog_mode_o = fld[6];
    assign fmt_sel_o     = fld[9:7];
endmodule

// File: rtl/hsp_checker.sv
module hsp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       latch_fall,
    input logic       sclk_fall,
    input logic       lock_err_i,
    input logic       sq_crc_ok_i,
    input logic       rd_is_cs_q,
    input logic       sout_o,
    input logic       sout_oe_o,
    input logic [9:0] cfg
);
    // R2, R10: configuration only moves on a strobe fall
    a_r10_cfg_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(latch_fall));

    // R8: the enable rises only on a strobe fall
    a_r8_oe_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sout_oe_o) |-> $past(latch_fall));

    // R5: channel-status flag is 1
    a_r5_cs_flag_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sout_oe_o) && rd_is_cs_q) |-> sout_o);

    // R6: subcode Q flag follows the check result
    a_r6_sq_flag_crc: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sout_oe_o) && !rd_is_cs_q) |-> (sout_o == $past(sq_crc_ok_i)));

    // R11: data moves only after a falling shift edge or a lock clear
    a_r11_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sout_oe_o && $past(sout_oe_o) && !$stable(sout_o))
            |-> ($past(sclk_fall) || $past(lock_err_i)));

    // R9: lock error zeroes a channel-status readout
    a_r9_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sout_oe_o && rd_is_cs_q && lock_err_i) |=> !sout_o);
endmodule

bind host_serial_port hsp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_fall  (latch_fall),
    .sclk_fall   (sclk_fall),
    .lock_err_i  (lock_err_i),
    .sq_crc_ok_i (sq_crc_ok_i),
    .rd_is_cs_q  (rd_is_cs_q),
    .sout_o      (sout_o),
    .sout_oe_o   (sout_oe_o),
    .cfg         ({fmt_sel_o, analog_mode_o, echo_vflag_o, echo_sel_o, demod_sel_o, sys_stop_o})
);

// File: tb/sim_host_serial_port.sv
module sim_host_serial_port;
    localparam int CS_W = 32;
    localparam int SQ_W = 80;
    localparam int LIMIT = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, latch = 1'b0, lock_err = 1'b0;
    logic [CS_W-1:0] cs_word = 32'hA5C3_1E69;
    logic [SQ_W-1:0] sq_word = 80'h1234_5678_9ABC_DEF0_0FF1;
    logic sq_ok = 1'b1;
    logic sout, sout_oe, sys_stop, echo_vflag, analog_mode;
    logic [1:0] demod_sel, echo_sel;
    logic [2:0] fmt_sel;

    always #10 clk = ~clk;

    host_serial_port #(.CS_W(CS_W), .SQ_W(SQ_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .latch_i(latch),
        .lock_err_i(lock_err), .cs_word_i(cs_word), .sq_word_i(sq_word),
        .sq_crc_ok_i(sq_ok), .sout_o(sout), .sout_oe_o(sout_oe),
        .sys_stop_o(sys_stop), .demod_sel_o(demod_sel), .echo_sel_o(echo_sel),
        .echo_vflag_o(echo_vflag), .analog_mode_o(analog_mode), .fmt_sel_o(fmt_sel)
    );

    // behavioural reference model
    int   mode = 0;            // 0 idle, 1 write, 2 read
    bit   abits[$];
    bit   wbits[$];
    bit   rq[$];
    bit   is_cs = 0;
    logic [9:0] exp_cfg = '0;
    string tag = "R4";

    int cycle = 0;
    int hold_until = 0;
    int vectors = 0;
    int fails = 0;

    function automatic bit exp_bit();
        return (rq.size() > 0) ? rq[0] : 1'b0;
    endfunction

    task automatic m_load(input bit flag, input logic [SQ_W-1:0] w, input int nbytes);
        rq.delete();
        rq.push_back(flag);
        for (int b = nbytes - 1; b >= 0; b--)
            for (int i = 0; i < 8; i++) rq.push_back(w[b*8 + i]);
    endtask

    task automatic m_latch_fall();
        if (mode == 0) begin
            if (abits.size() >= 8) begin
                logic [7:0] a;
                for (int k = 0; k < 8; k++) a[7-k] = abits[abits.size()-8+k];
                if (a == 8'b0101_0111) begin
                    mode = 1; wbits.delete();
                end else if (a == 8'b1001_0111) begin
                    mode = 2; is_cs = 1; m_load(1'b1, SQ_W'(cs_word), CS_W/8);
                end else if (a == 8'b0001_0111) begin
                    mode = 2; is_cs = 0; m_load(sq_ok, sq_word, SQ_W/8);
                end
            end
            abits.delete();
        end else if (mode == 1) begin
            if (wbits.size() >= 16)
                for (int k = 0; k < 10; k++) exp_cfg[k] = wbits[4+k];
            mode = 0; abits.delete();
        end
    endtask

    // per-clock comparison
    always @(negedge clk) begin
        cycle <= cycle + 1;
        if (cycle >= LIMIT) begin
            $display("FAIL watchdog: run hung at cycle %0d (act running, exp finished)", cycle);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails + 1);
            $finish;
        end
        if (cycle > 2 && cycle >= hold_until) begin
            vectors <= vectors + 1;
            if (sout_oe !== (mode == 2)) begin
                fails <= fails + 1;
                $display("FAIL %s: sout_oe act %b exp %b", tag, sout_oe, (mode == 2));
            end else if (sout_oe && sout !== exp_bit()) begin
                fails <= fails + 1;
                $display("FAIL %s: sout act %b exp %b", tag, sout, exp_bit());
            end
            if ({fmt_sel, analog_mode, echo_vflag, echo_sel, demod_sel, sys_stop} !== exp_cfg) begin
                fails <= fails + 1;
                $display("FAIL %s: cfg act %b exp %b", tag,
                    {fmt_sel, analog_mode, echo_vflag, echo_sel, demod_sel, sys_stop}, exp_cfg);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R11: a rising shift edge leaves every output alone, so no blind window there
    task automatic send_bit(input bit b);
        @(negedge clk); sdata = b;
        idle(3);
        sclk = 1'b1;
        if (mode == 0) abits.push_back(b);
        else if (mode == 1) wbits.push_back(b);
        idle(4);
        hold_until = cycle + 7;
        sclk = 1'b0;
        if (mode == 2 && rq.size() > 0) void'(rq.pop_front());
        idle(4);
    endtask

    task automatic latch_pulse();
        @(negedge clk);
        hold_until = cycle + 7;
        latch = 1'b1;
        if (mode == 2) begin mode = 0; abits.delete(); end
        idle(5);
        hold_until = cycle + 7;
        latch = 1'b0;
        m_latch_fall();
        idle(6);
    endtask

    task automatic send_addr(input logic [7:0] a);
        for (int i = 7; i >= 0; i--) send_bit(a[i]);
        latch_pulse();
    endtask

    task automatic write_cmd(input logic [31:0] w, input int nbits);
        send_addr(8'b0101_0111);
        for (int i = 0; i < nbits; i++) send_bit(w[i]);
        latch_pulse();
    endtask

    task automatic lock_pulse();
        @(negedge clk);
        hold_until = cycle + 7;
        lock_err = 1'b1;
        if (mode == 2 && is_cs) rq.delete();
        idle(3);
        lock_err = 1'b0;
        idle(4);
    endtask

    task automatic readout(input logic [7:0] a, input int nread, input int lock_at);
        send_addr(a);
        for (int k = 0; k < nread; k++) begin
            if (k == lock_at) lock_pulse();
            send_bit(1'b0);
        end
        latch_pulse();
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        tag = "R4"; idle(10);

        tag = "R2";  write_cmd(32'h0000_2B70, 16);          // fields set, ignored bits 0
        idle(4);
        tag = "R3";  write_cmd(32'h0000_C00F | 32'h0000_1490, 16); // ignored bits all 1
        idle(4);
        tag = "R10"; write_cmd(32'h0000_3FF0, 12);          // short: unchanged
        idle(4);
        tag = "R2";  write_cmd(32'h0003_0A50, 18);          // extra bits dropped
        idle(4);
        tag = "R1";  send_addr(8'hFF);                      // unknown address
        send_bit(1'b1); send_bit(1'b0);
        latch_pulse();
        tag = "R1";  send_addr(8'b0101_0110);               // near miss
        latch_pulse();

        tag = "R5";  readout(8'b1001_0111, 34, -1);
        tag = "R6";  readout(8'b0001_0111, 82, -1);
        sq_ok = 1'b0; sq_word = 80'hFEDC_BA98_7654_3210_8001;
        tag = "R7";  readout(8'b0001_0111, 81, -1);
        cs_word = 32'h8000_00FF;
        tag = "R7";  readout(8'b1001_0111, 33, -1);
        cs_word = 32'hFFFF_FFFF;
        tag = "R9";  readout(8'b1001_0111, 20, 6);          // lock clears
        tag = "R9";  readout(8'b0001_0111, 20, 6);          // lock ignored
        tag = "R8";  write_cmd(32'h0000_7FF0, 16);
        tag = "R11"; idle(10);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule